// File: doc/BRIEF.md
# Three-Level Control Line Step Counter

This block turns one control wire that rests at a middle level into up and down steps for a small setting register. Two comparators outside the block report whether the wire sits above an upper threshold or below a lower one. A swing toward the lower rail raises the setting by one. A swing toward the upper rail lowers it by one. The register value drives a DAC code output. An external controller nudges the output one step at a time until the result looks right.

Both comparator flags pass through synchronizers. Each swing is then timed against a width threshold, and glitches are thrown away. A swing counts only after the wire has rested at the middle level for a minimum time. The first swing that qualifies after power-up is discarded, because the comparators may wake up in an undefined state. An enable input gates all counting. A synchronous load port presets the register, for example with a value recalled from non-volatile storage.

Top module: `tri_level_stepper`

## Requirements
- R1: After reset the code output holds mid-scale, 2^(CODE_W-1) (64 with the default 7-bit width).
- R2: A qualified excursion below the low threshold raises the code by exactly one. A qualified excursion above the high threshold lowers it by exactly one.
- R3: An excursion is qualified only if it lasts at least QUAL_CYC = (REJECT_CYC+ACCEPT_CYC)/2 clock cycles (10 by default). So an excursion of REJECT_CYC cycles or fewer never counts, and one of ACCEPT_CYC cycles or more always counts.
- R4: Each excursion gives at most one step, however long it lasts.
- R5: An excursion is eligible only if the line sat at mid for at least GAP_CYC+1 consecutive cycles (5 by default) just before it started. An excursion that follows a shorter rest gives no step.
- R6: The first excursion that qualifies while enable is high, counted after reset or after a power_up strobe, gives no step. Later qualified excursions step normally.
- R7: While enable is low, excursions change nothing, and they do not use up the discard of R6.
- R8: The code saturates. It stays at 127 on further increments and at 0 on further decrements, and never wraps.
- R9: When load_en is high, the code takes load_val on the next clock edge. This load wins over any step in the same cycle.
- R10: When both comparator flags are high at once, the line is treated as being at mid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, taken as power-up |
| enable | input | 1 | Allows steps while high |
| power_up | input | 1 | One-cycle strobe that re-arms the first-excursion discard |
| above_hi | input | 1 | Asynchronous comparator flag: line above the high threshold |
| below_lo | input | 1 | Asynchronous comparator flag: line below the low threshold |
| load_en | input | 1 | Synchronous load strobe |
| load_val | input | CODE_W | Value written by a load |
| code | output | CODE_W | Saturating setting, used as the DAC code |

## Verification
The hardest case to reach from the ports is the spacing rule. A second excursion must start while the qualifier is still counting rest cycles after an earlier one, and this must be checked against an excursion that starts just after the rest window closes. The bench drives two back-to-back excursions, with rest gaps both below and above GAP_CYC+1 cycles. It also sweeps the excursion width across every value from one cycle up to past ACCEPT_CYC, and it predicts the count from the threshold formula. The one-time discard is reached again later in the run by a power_up strobe. That strobe is followed first by a disabled excursion and then by enabled ones.

// File: rtl/tls_pkg.sv
// Shared types for the three-level step counter.
// Assumes: the comparator flags have been synchronized before they are decoded.
package tls_pkg;
    typedef enum logic [1:0] {
        LVL_MID  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } level_t;

    typedef enum logic [1:0] {
        Q_REST   = 2'd0,  // counting rest cycles at mid
        Q_ARMED  = 2'd1,  // rest satisfied, waiting for an excursion
        Q_TIMING = 2'd2,  // timing an excursion
        Q_SPENT  = 2'd3   // excursion stepped, waiting for mid
    } qstate_t;
endpackage

// File: rtl/tls_sync.sv
// Multi-stage synchronizer, one lane per bit.
// Assumes: STAGES >= 2. Every lane resets to 0, which reads as the idle level.
module tls_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_lane
            logic [STAGES-1:0] shreg;
            // Shift the asynchronous bit through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[STAGES-2:0], d[b]};
            end
            assign q[b] = shreg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tls_qualifier.sv
// Times excursions of the synchronized line. It raises `fire` for one cycle on
// the QUAL_CYC-th cycle of an excursion that followed GAP_CYC+1 rest cycles.
// Assumes: QUAL_CYC >= 2 and GAP_CYC >= 1. Both flags high decodes as mid.
module tls_qualifier
    import tls_pkg::*;
#(
    parameter int QUAL_CYC = 10,
    parameter int GAP_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi,
    input  logic lo,
    output logic fire,
    output logic fire_up
);
    localparam int RUN_W = $clog2(QUAL_CYC + 1);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    level_t           lvl;
    level_t           dir;
    qstate_t          state;
    logic [RUN_W-1:0] run_cnt;
    logic [GAP_W-1:0] gap_cnt;

    // Decode the two flags into one line level.
    always_comb begin
        if (hi && !lo)      lvl = LVL_HIGH;
        else if (lo && !hi) lvl = LVL_LOW;
        else                lvl = LVL_MID;
    end

    // Fire on the cycle the excursion reaches the qualification width.
    always_comb begin
        fire    = (state == Q_TIMING) && (lvl == dir) &&
                  (run_cnt == RUN_W'(QUAL_CYC - 1));
        fire_up = (dir == LVL_LOW);
    end

    // Rest, arm, time and spend sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= Q_REST;
            dir     <= LVL_MID;
            run_cnt <= '0;
            gap_cnt <= '0;
        end else begin
            unique case (state)
                Q_REST: begin
                    if (lvl != LVL_MID) begin
                        gap_cnt <= '0;
                    end else if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                        gap_cnt <= '0;
                        state   <= Q_ARMED;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                Q_ARMED: begin
                    if (lvl != LVL_MID) begin
                        dir     <= lvl;
                        run_cnt <= RUN_W'(1);
                        state   <= Q_TIMING;
                    end
                end
                Q_TIMING: begin
                    if (lvl != dir) begin
                        gap_cnt <= '0;
                        state   <= Q_REST;
                    end else if (run_cnt == RUN_W'(QUAL_CYC - 1)) begin
                        state   <= Q_SPENT;
                    end else begin
                        run_cnt <= run_cnt + 1'b1;
                    end
                end
                Q_SPENT: begin
                    if (lvl == LVL_MID) begin
                        gap_cnt <= '0;
                        state   <= Q_REST;
                    end
                end
                default: state <= Q_REST;
            endcase
        end
    end
endmodule

// File: rtl/tls_sat_counter.sv
// Saturating up/down register with a synchronous load that wins over steps.
// Assumes: inc and dec are never high together.
module tls_sat_counter #(
    parameter int W         = 7,
    parameter int RESET_VAL = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = '1;

    // Load first, then clamped increment or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                  q <= W'(RESET_VAL);
        else if (load)               q <= load_val;
        else if (inc && q != TOP)    q <= q + 1'b1;
        else if (dec && q != '0)     q <= q - 1'b1;
    end
endmodule

// File: rtl/tri_level_stepper.sv
// Top level: synchronizes the comparator flags, qualifies excursions, discards
// the first qualified excursion after power-up and steps a saturating code.
// Assumes: enable, power_up, load_en and load_val are synchronous to clk.
module tri_level_stepper #(
    parameter int CODE_W      = 7,
    parameter int REJECT_CYC  = 4,
    parameter int ACCEPT_CYC  = 16,
    parameter int GAP_CYC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              power_up,
    input  logic              above_hi,
    input  logic              below_lo,
    input  logic              load_en,
    input  logic [CODE_W-1:0] load_val,
    output logic [CODE_W-1:0] code
);
    localparam int QUAL_CYC = (REJECT_CYC + ACCEPT_CYC) / 2;
    localparam int MID_CODE = 1 << (CODE_W - 1);

    logic [1:0] flags_s;
    logic       fire;
    logic       fire_up;
    logic       first_pending;
    logic       accept;
    logic       step_up;
    logic       step_dn;

    tls_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({above_hi, below_lo}),
        .q     (flags_s)
    );

    tls_qualifier #(.QUAL_CYC(QUAL_CYC), .GAP_CYC(GAP_CYC)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi      (flags_s[1]),
        .lo      (flags_s[0]),
        .fire    (fire),
        .fire_up (fire_up)
    );

    // Track whether the next enabled qualified excursion must be discarded.
    always_ff @(posedge clk) begin
        if (!rst_n)              first_pending <= 1'b1;
        else if (power_up)       first_pending <= 1'b1;
        else if (fire && enable) first_pending <= 1'b0;
    end

    // Gate qualified excursions into step commands.
    always_comb begin
        accept  = fire && enable && !first_pending;
        step_up = accept && fire_up;
        step_dn = accept && !fire_up;
    end

    tls_sat_counter #(.W(CODE_W), .RESET_VAL(MID_CODE)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .load_val (load_val),
        .inc      (step_up),
        .dec      (step_dn),
        .q        (code)
    );
endmodule

// File: rtl/tri_level_stepper_chk.sv
// Property checker for tri_level_stepper, attached by bind below.
module tri_level_stepper_chk #(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              power_up,
    input logic              load_en,
    input logic [CODE_W-1:0] load_val,
    input logic [CODE_W-1:0] code,
    input logic              step_up,
    input logic              step_dn
);
    // R2
    step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));

    // R4
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (({1'b0, code} == {1'b0, $past(code)}) ||
                      ({1'b0, code} == {1'b0, $past(code)} + 1'b1) ||
                      ({1'b0, code} + 1'b1 == {1'b0, $past(code)})));

    // R6
    first_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_up |=> !step_up && !step_dn);

    // R7
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !load_en |=> code == $past(code));

    // R8
    top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '1) && !load_en |=> code != '0);

    // R8
    bottom_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) && !load_en |=> code != '1);

    // R9
    load_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> code == $past(load_val));
endmodule

bind tri_level_stepper tri_level_stepper_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .power_up (power_up),
    .load_en  (load_en),
    .load_val (load_val),
    .code     (code),
    .step_up  (step_up),
    .step_dn  (step_dn)
);

// File: tb/tb_tri_level_stepper.sv
// Self-checking bench: width sweep, spacing, discard, enable, saturation, load.
module tb_tri_level_stepper;
    localparam int W      = 7;
    localparam int REJ    = 4;
    localparam int ACC    = 16;
    localparam int GAP    = 4;
    localparam int QUAL   = (REJ + ACC) / 2;
    localparam int SETTLE = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         power_up = 1'b0;
    logic         above_hi = 1'b0;
    logic         below_lo = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] code;

    int checks = 0;
    int errors = 0;
    int expv;

    always #10 clk = ~clk;

    tri_level_stepper #(.CODE_W(W), .REJECT_CYC(REJ), .ACCEPT_CYC(ACC),
                        .GAP_CYC(GAP), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .power_up(power_up),
        .above_hi(above_hi), .below_lo(below_lo), .load_en(load_en),
        .load_val(load_val), .code(code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // dn=1 drives the line high (decrement), dn=0 drives it low (increment).
    task automatic excursion(input bit dn, input int width, input int rest);
        above_hi = dn;
        below_lo = !dn;
        idle(width);
        above_hi = 1'b0;
        below_lo = 1'b0;
        idle(rest);
    endtask

    task automatic load(input int v);
        load_val = W'(v);
        load_en  = 1'b1;
        idle(1);
        load_en  = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 reset mid-scale", code, 64);
        enable = 1'b1;
        idle(SETTLE);

        // R6: first qualified excursion after reset is discarded.
        excursion(1'b0, 20, SETTLE);
        chk("R6 first discarded", code, 64);
        // R2: increment and decrement.
        excursion(1'b0, 20, SETTLE);
        chk("R2 low increments", code, 65);
        excursion(1'b1, 20, SETTLE);
        chk("R2 high decrements", code, 64);

        // R3: width sweep, both directions.
        load(40);
        idle(SETTLE);
        expv = 40;
        for (int w = 1; w <= ACC + 4; w++) begin
            excursion(1'b0, w, SETTLE);
            if (w >= QUAL) expv++;
            chk($sformatf("R3 low width %0d", w), code, expv);
        end
        for (int w = 1; w <= ACC + 4; w++) begin
            excursion(1'b1, w, SETTLE);
            if (w >= QUAL) expv--;
            chk($sformatf("R3 high width %0d", w), code, expv);
        end

        // R4: a very long excursion gives a single step.
        load(64);
        idle(SETTLE);
        excursion(1'b0, 100, SETTLE);
        chk("R4 long excursion one step", code, 65);

        // R5: rest too short, then just long enough.
        excursion(1'b0, 12, 2);
        excursion(1'b0, 12, SETTLE);
        chk("R5 short rest blocks second", code, 66);
        excursion(1'b0, 12, GAP + 1);
        excursion(1'b0, 12, SETTLE);
        chk("R5 sufficient rest counts both", code, 68);

        // R10: both flags high count as mid.
        above_hi = 1'b1;
        below_lo = 1'b1;
        idle(30);
        above_hi = 1'b0;
        below_lo = 1'b0;
        idle(SETTLE);
        chk("R10 both flags is mid", code, 68);

        // R8: saturation at both ends.
        load(126);
        idle(SETTLE);
        for (int k = 0; k < 3; k++) excursion(1'b0, 20, SETTLE);
        chk("R8 top saturation", code, 127);
        load(1);
        idle(SETTLE);
        for (int k = 0; k < 3; k++) excursion(1'b1, 20, SETTLE);
        chk("R8 bottom saturation", code, 0);

        // R9: load value and load priority over a step.
        load(100);
        chk("R9 load value", code, 100);
        load_val = W'(33);
        load_en  = 1'b1;
        excursion(1'b0, 20, 2);
        load_en  = 1'b0;
        idle(SETTLE);
        chk("R9 load beats step", code, 33);

        // R7 and R6: disabled excursions ignored and do not use the discard.
        enable = 1'b0;
        excursion(1'b0, 20, SETTLE);
        chk("R7 disabled no step", code, 33);
        power_up = 1'b1;
        idle(1);
        power_up = 1'b0;
        idle(SETTLE);
        excursion(1'b1, 20, SETTLE);
        chk("R7 disabled after power_up", code, 33);
        enable = 1'b1;
        excursion(1'b1, 20, SETTLE);
        chk("R6 discard after power_up", code, 33);
        excursion(1'b1, 20, SETTLE);
        chk("R6 next counts", code, 32);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule